// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a single first-in first-out channel. A write clock and a read clock, which need not be related, each drive their own side. The data path is nine bits wide by default, and the depth is two to the power `AW`. Four active-low status flags report the fill state:
- full and almost-full belong to the write clock;
- empty and almost-empty belong to the read clock.

Each pointer crosses to the other domain as Gray code through two flip-flops. A flag therefore asserts in the same cycle as the pointer move in its own domain. It releases only when the pointer copied from the other side catches up.

The `wen2_ld` pin is shared between two uses. The block decides which use applies by sampling the pin on write-clock edges while reset is held.
- **Second-write-enable mode** (pin high during reset). The pin is a second write enable, and the two threshold offsets keep their reset default.
- **Load mode** (pin low during reset). The pin is a strobe. With the strobe low, write-side enables store the offsets and read-side enables return them on the data output.

The data output is held in a register. It drives only while the output enable is low.

Top module: `fifo_dc`

## Requirements
- R1: While `rst_n` is low, both pointers return to the first location. In the first cycle after reset, `ff_n` and `paf_n` read 1, `ef_n` and `pae_n` read 0, and both offsets hold `DEF_OFF` (7).
- R2: A data write occurs on a `wclk` rise when `wen1_n` is 0 and `wen2_ld` is 1, in either mode. With `wen2_ld` at 0, no data is stored. The mode is the value of `wen2_ld` at the last `wclk` rise with `rst_n` low: 1 selects second-write-enable mode and 0 selects load mode.
- R3: A data read occurs on an `rclk` rise only when `ren1_n` and `ren2_n` are both 0 and `ef_n` is 1. It loads the oldest word into the output register, so words leave in write order. With either enable at 1, the output does not change.
- R4: `ff_n` is 0 exactly when the write side sees `2**AW` stored words. A write attempted while `ff_n` is 0 is dropped.
- R5: `ef_n` is 0 when the read side sees no stored word, and a read attempted then is dropped. A write becomes visible to the read side two `rclk` rises after the write edge.
- R6: `pae_n` is 0 exactly when the fill level seen on the read side is at or below the empty offset.
- R7: `paf_n` is 0 exactly when the free space seen on the write side is at or below the full offset. A read becomes visible to the write side two `wclk` rises after the read edge.
- R8: In load mode, a `wclk` rise with `wen1_n` at 0 and `wen2_ld` at 0 stores `din[AW-1:0]` into an offset register. The stores alternate: the empty offset first, then the full offset, then the empty offset again, and so on.
- R9: In load mode, an `rclk` rise with both read enables at 0 and `wen2_ld` at 0 puts the next offset on the output, zero-extended. Offset reads follow the same alternation as R8. An offset read leaves the FIFO contents and the read pointer untouched.
- R10: In second-write-enable mode, both offsets stay at 7. With 7 words stored, `pae_n` is 0; with 8 words stored, it is 1.
- R11: `dout` is high-impedance while `oe_n` is 1, and carries the output register while `oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset; `wclk` must run while it is low so that the mode is sampled |
| din | input | DW | Write data; low AW bits carry an offset during an offset store |
| wen1_n | input | 1 | Active-low write enable |
| wen2_ld | input | 1 | Second write enable (high active) or active-low offset strobe, depending on the mode |
| ren1_n | input | 1 | Active-low read enable, first of two |
| ren2_n | input | 1 | Active-low read enable, second of two |
| oe_n | input | 1 | Active-low output enable |
| dout | output | DW | Registered read data or offset value, tri-stated by `oe_n` |
| ef_n | output | 1 | Empty flag, active low, read domain |
| pae_n | output | 1 | Almost-empty flag, active low, read domain |
| ff_n | output | 1 | Full flag, active low, write domain |
| paf_n | output | 1 | Almost-full flag, active low, write domain |

## Verification
The main data path is tried with several input patterns:
- **Writes with the second enable held low.** The empty flag staying low shows that a half-asserted enable is ignored.
- **A run of 7 words, then an eighth.** This finds the default almost-empty edge.
- **Overfilling past full.** This shows that dropped writes leave no trace in the data read back later.
- **A single read enable asserted.** This separates the two-enable read from a one-enable read.
- **Simultaneous reads and writes with the output enable toggling.** This exposes off-by-one errors in the flag latency and mixes the tri-state check in with the data.

In load mode, offset stores and offset reads are interleaved with stored data. The word read after the offsets must still be the oldest word, which shows that offset access neither moves the read pointer nor takes a word from memory. The programmed thresholds then move both almost flags to new fill levels.

// File: rtl/fifo_dc.sv
module fifo_dc #(
  parameter int DW      = 9,
  parameter int AW      = 8,
  parameter int DEF_OFF = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          ef_n,
  output logic          pae_n,
  output logic          ff_n,
  output logic          paf_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, rbin, wgray, rgray;
  logic [PW-1:0] wq1, wq2, rq1, rq2;
  logic [PW-1:0] wcount, rcount, wfree;
  logic [AW-1:0] eoff, foff;
  logic          sel_w, sel_r, mode_we;
  logic [DW-1:0] q;
  logic          wr_en, off_wr, rd_req, off_rd, rd_en;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // mode is taken from the shared pin on write-clock edges inside reset
  always_ff @(posedge wclk)
    if (!rst_n) mode_we <= wen2_ld;

  assign wcount = wbin - from_gray(rq2);
  assign wfree  = PW'(DEPTH) - wcount;
  assign rcount = from_gray(wq2) - rbin;

  assign ff_n  = wcount != PW'(DEPTH);
  assign paf_n = !(wfree <= {1'b0, foff});
  assign ef_n  = rcount != '0;
  assign pae_n = !(rcount <= {1'b0, eoff});

  assign wr_en  = !wen1_n && wen2_ld && ff_n;
  assign off_wr = !mode_we && !wen1_n && !wen2_ld;
  assign rd_req = !ren1_n && !ren2_n;
  assign off_rd = rd_req && !mode_we && !wen2_ld;
  assign rd_en  = rd_req && !off_rd && ef_n;

  // write domain
  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_en) begin
      wbin  <= wbin + 1'b1;
      wgray <= to_gray(wbin + 1'b1);
    end

  always_ff @(posedge wclk)
    if (wr_en) mem[wbin[AW-1:0]] <= din;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      rq1 <= '0;
      rq2 <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
    end

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      eoff  <= AW'(DEF_OFF);
      foff  <= AW'(DEF_OFF);
      sel_w <= 1'b0;
    end else if (off_wr) begin
      if (sel_w) foff <= din[AW-1:0];
      else       eoff <= din[AW-1:0];
      sel_w <= !sel_w;
    end

  // read domain
  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_en) begin
      rbin  <= rbin + 1'b1;
      rgray <= to_gray(rbin + 1'b1);
    end

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      wq1 <= '0;
      wq2 <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
    end

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      q     <= '0;
      sel_r <= 1'b0;
    end else if (off_rd) begin
      q     <= DW'(sel_r ? foff : eoff);
      sel_r <= !sel_r;
    end else if (rd_en) begin
      q     <= mem[rbin[AW-1:0]];
    end

  assign dout = oe_n ? {DW{1'bz}} : q;

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wclk) disable iff (!rst_n)
    !ff_n |=> $stable(wbin)); // R4
  AST_NO_READ_WHEN_EMPTY: assert property (@(posedge rclk) disable iff (!rst_n)
    !ef_n |=> $stable(rbin)); // R5
  AST_FULL_IMPLIES_ALMOST_FULL: assert property (@(posedge wclk) disable iff (!rst_n)
    !ff_n |-> !paf_n); // R7
  AST_EMPTY_IMPLIES_ALMOST_EMPTY: assert property (@(posedge rclk) disable iff (!rst_n)
    !ef_n |-> !pae_n); // R6
  AST_OFFSET_READ_KEEPS_POINTER: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_req && !mode_we && !wen2_ld) |=> $stable(rbin)); // R9
  AST_ENABLE_MODE_DEFAULTS: assert property (@(posedge wclk) disable iff (!rst_n)
    mode_we |-> (eoff == AW'(DEF_OFF) && foff == AW'(DEF_OFF))); // R10
endmodule

// File: tb/sim_fifo_dc.sv
module sim_fifo_dc;
  localparam int DW = 9;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int DEF = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic          wen1_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b0;
  wire  [DW-1:0] dout;
  logic          ef_n, pae_n, ff_n, paf_n;

  for (genvar i = 0; i < DW; i++) begin : g_pu
    pullup pu (dout[i]);
  end

  fifo_dc #(.DW(DW), .AW(AW), .DEF_OFF(DEF)) u0 (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .din(din), .wen1_n(wen1_n),
    .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n),
    .dout(dout), .ef_n(ef_n), .pae_n(pae_n), .ff_n(ff_n), .paf_n(paf_n));

  int checks = 0, errors = 0;
  bit chk_on = 0;

  // behavioural reference
  int wc, rc, ws1, ws2, rs1, rs2, m_eoff, m_foff;
  bit m_selw, m_selr, m_mode;
  logic [DW-1:0] m_q;
  logic [DW-1:0] m_mem[$];
  string m_qtag = "R3";
  bit dw, dr, dlw, dlr, mf, me;

  always @(posedge clk)
    if (!rst_n) m_mode = wen2_ld;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc = 0; rc = 0; ws1 = 0; ws2 = 0; rs1 = 0; rs2 = 0;
      m_eoff = DEF; m_foff = DEF; m_selw = 0; m_selr = 0; m_q = '0;
      m_mem.delete();
    end else begin
      mf  = (wc - rs2) == DEPTH;
      me  = (ws2 - rc) == 0;
      dw  = !wen1_n && wen2_ld && !mf;
      dlw = !m_mode && !wen1_n && !wen2_ld;
      dlr = !m_mode && !ren1_n && !ren2_n && !wen2_ld;
      dr  = !ren1_n && !ren2_n && !dlr && !me;
      if (dlr) begin
        m_q = DW'(m_selr ? m_foff : m_eoff);
        m_selr = !m_selr;
        m_qtag = "R9";
      end else if (dr) begin
        m_q = m_mem.pop_front();
        m_qtag = "R3";
      end
      if (dlw) begin
        if (m_selw) m_foff = int'(din[AW-1:0]);
        else        m_eoff = int'(din[AW-1:0]);
        m_selw = !m_selw;
      end
      if (dw) m_mem.push_back(din);
      ws2 = ws1; ws1 = wc; rs2 = rs1; rs1 = rc;
      wc += int'(dw); rc += int'(dr);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    if (!chk_on) return;
    chk("R4 ff_n",  int'(ff_n),  int'((wc - rs2) != DEPTH));
    chk("R7 paf_n", int'(paf_n), int'(!((DEPTH - (wc - rs2)) <= m_foff)));
    chk("R5 ef_n",  int'(ef_n),  int'((ws2 - rc) != 0));
    chk("R6 pae_n", int'(pae_n), int'(!((ws2 - rc) <= m_eoff)));
    if (oe_n) chk("R11 dout hi-z", int'(dout), (1 << DW) - 1);
    else      chk({m_qtag, " dout"}, int'(dout), int'(m_q));
  endtask

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic do_reset(bit pin);
    rst_n = 1'b0; wen2_ld = pin; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    cyc(3);
    rst_n = 1'b1; wen2_ld = 1'b1;
    cyc(1);
    chk("R1 ff_n",  int'(ff_n),  1);
    chk("R1 paf_n", int'(paf_n), 1);
    chk("R1 ef_n",  int'(ef_n),  0);
    chk("R1 pae_n", int'(pae_n), 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(1);
    chk_on = 1;
    // second-write-enable mode
    do_reset(1'b1);
    wen1_n = 0; wen2_ld = 0; din = 9'h1aa;
    cyc(4);
    wen1_n = 1; wen2_ld = 1;
    cyc(3);
    chk("R2 write with second enable low ignored", int'(ef_n), 0);
    wen1_n = 0;
    for (int i = 0; i < 7; i++) begin din = DW'(i + 1); cyc(1); end
    wen1_n = 1; cyc(3);
    chk("R10 seven stored, default empty offset", int'(pae_n), 0);
    wen1_n = 0; din = 9'h008; cyc(1); wen1_n = 1; cyc(3);
    chk("R10 eight stored, default empty offset", int'(pae_n), 1);
    wen1_n = 0;
    for (int i = 0; i < DEPTH; i++) begin din = DW'(i * 3 + 9); cyc(1); end
    wen1_n = 1; cyc(1);
    chk("R4 full after overfill", int'(ff_n), 0);
    ren1_n = 0; cyc(3);
    ren1_n = 1; ren2_n = 0; cyc(2);
    ren1_n = 0;
    for (int i = 0; i < 100; i++) begin oe_n = (i % 7) == 3; cyc(1); end
    wen1_n = 0;
    for (int i = 0; i < 60; i++) begin din = DW'(i ^ 9'h155); oe_n = (i % 5) == 1; cyc(1); end
    wen1_n = 1; oe_n = 0;
    cyc(DEPTH + 20);
    ren1_n = 1; ren2_n = 1; cyc(3);
    chk("R5 drained", int'(ef_n), 0);

    // load mode
    do_reset(1'b0);
    wen1_n = 0;
    for (int i = 0; i < 20; i++) begin din = DW'(i + 9'h40); cyc(1); end
    wen2_ld = 0;
    din = 9'd3; cyc(1);
    din = 9'd10; cyc(1);
    din = 9'd5; cyc(1);
    wen1_n = 1;
    ren1_n = 0; ren2_n = 0; cyc(1);
    chk("R8 first offset read is empty offset", int'(dout), 5);
    cyc(1);
    chk("R8 second offset read is full offset", int'(dout), 10);
    cyc(1);
    chk("R8 offset read wraps", int'(dout), 5);
    wen2_ld = 1; cyc(1);
    chk("R9 oldest word kept after offset reads", int'(dout), 9'h40);
    ren1_n = 1; ren2_n = 1;
    wen1_n = 0;
    for (int i = 0; i < DEPTH; i++) begin din = DW'(i * 5); cyc(1); end
    wen1_n = 1; cyc(1);
    chk("R7 almost full with programmed offset", int'(paf_n), 0);
    ren1_n = 0; ren2_n = 0;
    cyc(DEPTH + 10);
    ren1_n = 1; ren2_n = 1; cyc(3);
    chk("R6 almost empty when drained", int'(pae_n), 0);
    finish_run();
  end
endmodule